// File: doc/BRIEF.md
# Robbed-Bit Signalling Debouncer

This block holds the four robbed-bit signalling bits (A, B, C, D) of every DS0 channel in a received DS1 stream. An upstream extractor supplies them as a stream of per-channel updates, each made of a channel number, a nibble and a valid strobe. When debouncing is enabled, a new nibble is accepted as the channel's reported state only after it has held steady for 6 to 9 ms. That time is measured against a shared 3 ms tick from outside the block. When debouncing is disabled, every update is reported at once.

The time-slot logic reads a channel's status byte by raising a read request with the channel number. The byte appears one cycle later, with the nibble in the low half and zeros in the high half. After reset the block clears its per-channel storage with one channel per cycle. During that sweep, updates are ignored and reads return zero.

Top module: `rbs_debounce`

## Requirements
- R1: The status byte carries A in bit 3, B in bit 2, C in bit 1 and D in bit 0, and bits 7..4 are always 0. The input nibble uses the same positions, with A in `upd_sig[3]`.
- R2: `stat_valid` is high exactly one cycle after `rd_req`. The byte shows the reported nibble as it stood before any update in the same cycle as the request.
- R3: After reset is released, the block spends NUM_CH cycles clearing its storage. Reads during that time return 0 and updates are ignored. Afterwards every channel reports 0.
- R4: With `dbnc_en` low, an update becomes the channel's reported nibble at once, and a read in any later cycle returns it.
- R5: With `dbnc_en` high, a new nibble is reported only when it has matched at the first update after each of three ticks since it first appeared. With a 3 ms tick this gives 6 to 9 ms of stability.
- R6: With `dbnc_en` high, an update that differs from the channel's candidate makes it the new candidate and restarts its count. The reported nibble keeps its old value.
- R7: Updates with no tick between them advance the count by at most one step. Several ticks between two updates count as one.
- R8: An update to a channel number of NUM_CH or more is ignored, and a read of such a channel returns 0.
- R9: A tick in the same cycle as an update of a channel counts toward that channel's next update, not this one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbnc_en | input | 1 | 1 = debounce, 0 = pass updates straight through |
| tick | input | 1 | Shared 3 ms timing pulse, one cycle wide |
| upd_valid | input | 1 | Update strobe |
| upd_chan | input | 5 | Channel number of the update |
| upd_sig | input | 4 | Extracted signalling nibble, A in bit 3 |
| rd_req | input | 1 | Status read request |
| rd_chan | input | 5 | Channel to read |
| stat_valid | output | 1 | Status byte valid |
| stat_byte | output | 8 | Per-channel status byte |

## Verification
Two pairs of functions can land in the same cycle. A status read of a channel can coincide with a write to that channel's reported nibble. The shared tick can coincide with an update. The bench provokes the first in bypass mode by issuing a read and an update of the same channel together. It expects the old nibble, and then the new one on a following read. It provokes the second by driving the tick and a matching update together. It then shows through reads that the report arrives one qualifying update later than it would have if that tick had counted at once.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int SIG_W  = 4;
  localparam int STAT_W = 8;

  typedef logic [SIG_W-1:0] sig_t;
  typedef logic [1:0]       pcnt_t;

  // persistence counter states: 0..2 counting, 3 = candidate already reported
  localparam pcnt_t PCNT_LAST = 2'd2;
  localparam pcnt_t PCNT_DONE = 2'd3;
endpackage

// File: rtl/rbs_pending.sv
module rbs_pending #(
  parameter int NUM_CH = 24,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              clr_en,
  input  logic [CH_W-1:0]   clr_chan,
  output logic [NUM_CH-1:0] pend_vec
);
  // one flag per channel: a tick has occurred since the channel's last update
  for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
    logic hit;
    assign hit = clr_en && (clr_chan == CH_W'(i));
    always_ff @(posedge clk) begin
      if (rst) pend_vec[i] <= 1'b0;
      else     pend_vec[i] <= tick | (pend_vec[i] & ~hit);
    end
  end
endmodule

// File: rtl/rbs_filter.sv
module rbs_filter
  import rbs_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init_busy,
  input  logic [CH_W-1:0] init_chan,
  input  logic            upd_fire,
  input  logic [CH_W-1:0] upd_chan,
  input  sig_t            upd_sig,
  input  logic            dbnc_en,
  input  logic            pend_hit,
  output logic            wr_en,
  output logic [CH_W-1:0] wr_chan,
  output sig_t            wr_data
);
  sig_t  cand_mem [NUM_CH];
  pcnt_t cnt_mem  [NUM_CH];

  sig_t            cand_q;
  pcnt_t           cnt_q;
  logic            st_we;
  logic [CH_W-1:0] st_addr;
  sig_t            cand_n;
  pcnt_t           cnt_n;

  assign cand_q = cand_mem[upd_chan];
  assign cnt_q  = cnt_mem[upd_chan];

  always_comb begin
    st_we   = 1'b0;
    st_addr = upd_chan;
    cand_n  = cand_q;
    cnt_n   = cnt_q;
    wr_en   = 1'b0;
    wr_chan = upd_chan;
    wr_data = cand_q;
    if (init_busy) begin
      st_we   = 1'b1;
      st_addr = init_chan;
      cand_n  = '0;
      cnt_n   = '0;
      wr_en   = 1'b1;
      wr_chan = init_chan;
      wr_data = '0;
    end else if (upd_fire) begin
      if (!dbnc_en) begin
        st_we   = 1'b1;
        cand_n  = upd_sig;
        cnt_n   = PCNT_DONE;
        wr_en   = 1'b1;
        wr_data = upd_sig;
      end else if (upd_sig != cand_q) begin
        st_we  = 1'b1;
        cand_n = upd_sig;
        cnt_n  = '0;
      end else if (pend_hit && cnt_q != PCNT_DONE) begin
        st_we = 1'b1;
        cnt_n = pcnt_t'(cnt_q + 2'd1);
        wr_en = (cnt_q == PCNT_LAST);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st_we) begin
      cand_mem[st_addr] <= cand_n;
      cnt_mem[st_addr]  <= cnt_n;
    end
  end

  AST_MISMATCH_NO_REPORT: assert property (@(posedge clk) disable iff (rst)
    (!init_busy && upd_fire && dbnc_en && upd_sig != cand_q) |-> !wr_en); // R6
endmodule

// File: rtl/rbs_status_mem.sv
module rbs_status_mem
  import rbs_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [CH_W-1:0] waddr,
  input  sig_t            wdata,
  input  logic [CH_W-1:0] raddr,
  output sig_t            rdata
);
  sig_t mem [NUM_CH];

  // read-before-write synchronous port pair
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rbs_debounce.sv
module rbs_debounce
  import rbs_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbnc_en,
  input  logic              tick,
  input  logic              upd_valid,
  input  logic [CH_W-1:0]   upd_chan,
  input  logic [SIG_W-1:0]  upd_sig,
  input  logic              rd_req,
  input  logic [CH_W-1:0]   rd_chan,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_byte
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic            init_busy;
  logic [CH_W-1:0] init_chan;
  logic            upd_in_rng;
  logic            upd_fire;
  logic [CH_W-1:0] upd_idx;
  logic            rd_ok;
  logic [CH_W-1:0] rd_idx;
  logic [NUM_CH-1:0] pend_vec;
  logic            pend_hit;
  logic            wr_en;
  logic [CH_W-1:0] wr_chan;
  sig_t            wr_data;
  sig_t            rdata;
  logic            zero_q;

  // clearing sweep after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      init_busy <= 1'b1;
      init_chan <= '0;
    end else if (init_busy) begin
      if (init_chan == LAST_CH) init_busy <= 1'b0;
      else                      init_chan <= init_chan + 1'b1;
    end
  end

  assign upd_in_rng = (upd_chan <= LAST_CH);
  assign upd_fire   = upd_valid && upd_in_rng && !init_busy;
  assign upd_idx    = upd_in_rng ? upd_chan : '0;
  assign pend_hit   = pend_vec[upd_idx];
  assign rd_ok      = (rd_chan <= LAST_CH) && !init_busy;
  assign rd_idx     = (rd_chan <= LAST_CH) ? rd_chan : '0;

  rbs_pending #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .clr_en   (upd_fire),
    .clr_chan (upd_idx),
    .pend_vec (pend_vec)
  );

  rbs_filter #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_filt (
    .clk       (clk),
    .rst       (rst),
    .init_busy (init_busy),
    .init_chan (init_chan),
    .upd_fire  (upd_fire),
    .upd_chan  (upd_idx),
    .upd_sig   (upd_sig),
    .dbnc_en   (dbnc_en),
    .pend_hit  (pend_hit),
    .wr_en     (wr_en),
    .wr_chan   (wr_chan),
    .wr_data   (wr_data)
  );

  rbs_status_mem #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_stat (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_chan),
    .wdata (wr_data),
    .raddr (rd_idx),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_valid <= 1'b0;
      zero_q     <= 1'b1;
    end else begin
      stat_valid <= rd_req;
      zero_q     <= !rd_ok;
    end
  end

  assign stat_byte = {4'b0000, (zero_q ? 4'b0000 : rdata)};

  AST_BYPASS_PASSES: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !dbnc_en) |-> (wr_en && wr_data == upd_sig)); // R4
  AST_REPORT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    (!init_busy && wr_en && dbnc_en) |-> pend_hit); // R5
  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_in_rng && !init_busy) |-> !wr_en); // R8
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && $past(init_busy)) |-> (stat_byte == '0)); // R3
endmodule

// File: tb/sim_rbs_debounce.sv
module sim_rbs_debounce;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dbnc_en = 1'b0;
  logic       tick = 1'b0;
  logic       upd_valid = 1'b0;
  logic [4:0] upd_chan = '0;
  logic [3:0] upd_sig = '0;
  logic       rd_req = 1'b0;
  logic [4:0] rd_chan = '0;
  logic       stat_valid;
  logic [7:0] stat_byte;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  rbs_debounce u0 (
    .clk(clk), .rst(rst), .dbnc_en(dbnc_en), .tick(tick),
    .upd_valid(upd_valid), .upd_chan(upd_chan), .upd_sig(upd_sig),
    .rd_req(rd_req), .rd_chan(rd_chan),
    .stat_valid(stat_valid), .stat_byte(stat_byte)
  );

  task automatic upd(input logic [4:0] ch, input logic [3:0] v);
    upd_valid = 1'b1; upd_chan = ch; upd_sig = v;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic tk();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic upd_tick(input logic [4:0] ch, input logic [3:0] v);
    tick = 1'b1; upd_valid = 1'b1; upd_chan = ch; upd_sig = v;
    @(negedge clk);
    tick = 1'b0; upd_valid = 1'b0;
  endtask

  task automatic rd(input logic [4:0] ch, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_req = 1'b1; rd_chan = ch;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic upd_rd(input logic [4:0] ch, input logic [3:0] v,
                        input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    upd_valid = 1'b1; upd_chan = ch; upd_sig = v;
    rd_req = 1'b1; rd_chan = ch;
    @(negedge clk);
    upd_valid = 1'b0; rd_req = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor: pops expected items as status bytes appear
  always @(negedge clk) begin
    if (!rst && stat_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected stat_valid actual=%02h expected=none", stat_byte);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (stat_byte !== e) begin
          n_fail++;
          $display("FAIL %s actual=%02h expected=%02h", t, stat_byte, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3: update and read during clearing sweep
    upd(5'd3, 4'h5);
    rd(5'd0, 8'h00, "R3 read during clear");
    repeat (30) @(negedge clk);
    rd(5'd3, 8'h00, "R3 update during clear ignored");
    for (int c = 0; c < 24; c++) rd(5'(c), 8'h00, "R3 cleared channel");
    // R4 / R1: bypass, bit positions
    upd(5'd5, 4'b1000);
    rd(5'd5, 8'h08, "R1 A in bit 3");
    upd(5'd5, 4'b0001);
    rd(5'd5, 8'h01, "R1 D in bit 0");
    upd(5'd6, 4'b1111);
    rd(5'd6, 8'h0F, "R4 bypass, R1 upper nibble zero");
    // R2: read and update of same channel in one cycle
    upd_rd(5'd5, 4'b0110, 8'h01, "R2 read returns old value");
    rd(5'd5, 8'h06, "R2 new value on next read");
    // R8: out-of-range channel
    upd(5'd26, 4'hF);
    rd(5'd26, 8'h00, "R8 out-of-range read");
    rd(5'd0, 8'h00, "R8 channel 0 untouched");
    // R5: three ticks needed
    dbnc_en = 1'b1;
    upd(5'd7, 4'h6);
    tk(); upd(5'd7, 4'h6);
    tk(); upd(5'd7, 4'h6);
    rd(5'd7, 8'h00, "R5 not reported after two ticks");
    tk(); upd(5'd7, 4'h6);
    rd(5'd7, 8'h06, "R5 reported after three ticks");
    // R6: mismatch restarts, report held
    upd(5'd7, 4'h1);
    rd(5'd7, 8'h06, "R6 report held on change");
    tk(); upd(5'd7, 4'h1);
    tk(); upd(5'd7, 4'h1);
    upd(5'd7, 4'h2);
    tk(); upd(5'd7, 4'h1);
    tk(); upd(5'd7, 4'h1);
    tk(); upd(5'd7, 4'h1);
    rd(5'd7, 8'h06, "R6 count restarted");
    tk(); upd(5'd7, 4'h1);
    rd(5'd7, 8'h01, "R6 reported after restart");
    // R7: updates without ticks, merged ticks
    upd(5'd11, 4'h9);
    for (int k = 0; k < 10; k++) upd(5'd11, 4'h9);
    rd(5'd11, 8'h00, "R7 no tick no progress");
    for (int k = 0; k < 5; k++) tk();
    upd(5'd11, 4'h9);
    tk(); upd(5'd11, 4'h9);
    rd(5'd11, 8'h00, "R7 several ticks count once");
    tk(); upd(5'd11, 4'h9);
    rd(5'd11, 8'h09, "R7 reported on third tick");
    // R9: tick coincident with update
    upd(5'd14, 4'h4);
    upd_tick(5'd14, 4'h4);
    upd(5'd14, 4'h4);
    tk(); upd(5'd14, 4'h4);
    rd(5'd14, 8'h00, "R9 coincident tick not counted at once");
    tk(); upd(5'd14, 4'h4);
    rd(5'd14, 8'h04, "R9 reported one update later");
    // R4: bypass after debounce
    dbnc_en = 1'b0;
    upd(5'd14, 4'h3);
    rd(5'd14, 8'h03, "R4 bypass immediate");
    repeat (4) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing stat_valid actual=%0d pending expected=0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule